// File: doc/BRIEF.md
# Bidirectional AES-128 Round-Key Stepper

This block holds one AES-128 round key as four 32-bit words and moves it one round per enabled clock. When moving forward it produces the next round key of the encryption schedule. When moving backward it recomputes the previous round key from the current one. As a result, a decryption engine can walk from the last round key back to the cipher key without storing the eleven expanded keys.

The byte substitution is not inside the block. The block sends one 32-bit word out on `sub_word_o` to S-boxes that the data path shares. The substituted word must come back on `sub_word_i` within the same cycle.

For decryption, the user loads the cipher key and steps forward ten times to reach round key 10. The user then raises the direction input and steps backward once per round. The round constant travels with the key state, so a backward step always uses the constant of the round it undoes.

Top module: `rks_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `round_key_o` is all zeros.
- R2: When `load_i` is high at a clock edge, `round_key_o` equals `key_i` after that edge. The round constant restarts at {01}, so the next forward step yields round key 1 of that key.
- R3: A forward step (`step_i`=1, `dir_back_i`=0) produces the next AES-128 expansion key:
  - W0' = W0 ^ S ^ {rc,000000}, where S is `sub_word_i`.
  - Each later word is Wi' = Wi ^ W(i-1)'.
  - W0 sits in bits 127:96 and W3 in bits 31:0.
  - The constant rc starts at {01} and is doubled in GF(2^8) (reduction 0x1b) after each forward step.
- R4: Starting from key 2b7e151628aed2a6abf7158809cf4f3c, ten forward steps give d014f9a8c9ee2589e13f0cc8b6630ca6.
- R5: A backward step (`dir_back_i`=1) exactly undoes the most recent forward step, including the constant. After n forward and n backward steps, the loaded key returns. This holds for n up to 12, which is beyond round 10.
- R6: `sub_word_o` equals RotWord(W3) when `dir_back_i`=0 and RotWord(W3^W2) when `dir_back_i`=1. RotWord moves bits 31:24 to bits 7:0.
- R7: With `load_i` and `step_i` both low, `round_key_o` keeps its value, whatever `dir_back_i`, `key_i` and `sub_word_i` do.
- R8: When `load_i` and `step_i` are both high, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load `key_i` and restart the round constant |
| key_i | input | 128 | Cipher key |
| step_i | input | 1 | Advance one round this cycle |
| dir_back_i | input | 1 | 0: step forward, 1: step backward |
| sub_word_i | input | 32 | S-box result for `sub_word_o` |
| round_key_o | output | 128 | Current round key, W0 in the top bits |
| sub_word_o | output | 32 | Word to be substituted |

## Verification
The bench targets the following corner cases:
- **Round key 10 of the standard key.** A wrong round constant or a wrong rotation direction gives a wrong round key 10.
- **Long forward-then-backward walks past round 10.** A wrong GF halving of the constant shows up once the walk crosses the 0x80/0x1b boundary and fails to return to the loaded key.
- **Backward substitution word.** A design that substitutes W3 instead of W3^W2 when stepping back drifts from the first backward step.
- **Idle cycles and load versus step.** Idle cycles with noisy inputs catch a design that updates without `step_i`. Driving load and step together catches a design that lets the step win.

// File: rtl/rks_pkg.sv
package rks_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_half(input logic [BYTE_W-1:0] b);
    return b[0] ? (((b ^ 8'h1b) >> 1) | 8'h80) : (b >> 1);
  endfunction
endpackage

// File: rtl/rks_rcon.sv
module rks_rcon
  import rks_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dir_back_i,
  output logic [BYTE_W-1:0] rc_use_o
);
  logic [BYTE_W-1:0] rc_q;

  // Forward uses the held constant; backward uses the one before it.
  assign rc_use_o = dir_back_i ? gf_half(rc_q) : rc_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) rc_q <= 8'h01;
    else if (step_i)   rc_q <= dir_back_i ? rc_use_o : gf_dbl(rc_q);
  end

  AST_RCON_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rc_q != '0); // R5
endmodule

// File: rtl/rks_words.sv
module rks_words
  import rks_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int KEY_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              step_i,
  input  logic              dir_back_i,
  input  logic [BYTE_W-1:0] rc_i,
  input  logic [WORD_W-1:0] sub_word_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [WORD_W-1:0] sub_word_o
);
  logic [WORD_W-1:0] w_q   [NWORDS];
  logic [WORD_W-1:0] w_fwd [NWORDS];
  logic [WORD_W-1:0] w_rev [NWORDS];
  logic [WORD_W-1:0] rc_word;

  assign rc_word = {rc_i, {(WORD_W-BYTE_W){1'b0}}};

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    if (i == 0) begin : g_head
      assign w_fwd[i] = w_q[i] ^ sub_word_i ^ rc_word;
      assign w_rev[i] = w_q[i] ^ sub_word_i ^ rc_word;
    end else begin : g_tail
      assign w_fwd[i] = w_q[i] ^ w_fwd[i-1];
      assign w_rev[i] = w_q[i] ^ w_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)          w_q[i] <= '0;
      else if (load_i)  w_q[i] <= key_i[KEY_W-1-i*WORD_W -: WORD_W];
      else if (step_i)  w_q[i] <= dir_back_i ? w_rev[i] : w_fwd[i];
    end

    assign key_o[KEY_W-1-i*WORD_W -: WORD_W] = w_q[i];
  end

  assign sub_word_o = rot_word(dir_back_i ? w_rev[NWORDS-1] : w_q[NWORDS-1]);

  AST_LOAD_TAKES_KEY: assert property (@(posedge clk) disable iff (rst)
    load_i |=> key_o == $past(key_i)); // R2
  AST_FWD_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (step_i && !dir_back_i && !load_i) |=>
      key_o[KEY_W-1-WORD_W -: WORD_W] ==
      ($past(key_o[KEY_W-1-WORD_W -: WORD_W]) ^ key_o[KEY_W-1 -: WORD_W])); // R3
  AST_REV_LAST: assert property (@(posedge clk) disable iff (rst)
    (step_i && dir_back_i && !load_i) |=>
      key_o[WORD_W-1:0] == $past(key_o[WORD_W-1:0] ^ key_o[2*WORD_W-1:WORD_W])); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(key_o)); // R7
endmodule

// File: rtl/rks_top.sv
module rks_top
  import rks_pkg::*;
#(
  parameter int NWORDS = 4,
  localparam int KEY_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              step_i,
  input  logic              dir_back_i,
  input  logic [WORD_W-1:0] sub_word_i,
  output logic [KEY_W-1:0]  round_key_o,
  output logic [WORD_W-1:0] sub_word_o
);
  logic [BYTE_W-1:0] rc_use;

  rks_rcon u_rcon (
    .clk(clk), .rst(rst), .load_i(load_i), .step_i(step_i),
    .dir_back_i(dir_back_i), .rc_use_o(rc_use)
  );

  rks_words #(.NWORDS(NWORDS)) u_words (
    .clk(clk), .rst(rst), .load_i(load_i), .key_i(key_i),
    .step_i(step_i), .dir_back_i(dir_back_i), .rc_i(rc_use),
    .sub_word_i(sub_word_i), .key_o(round_key_o), .sub_word_o(sub_word_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> round_key_o == '0); // R1
endmodule

// File: tb/rks_top_test.sv
module rks_top_test;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst = 1, load_i = 0, step_i = 0, dir_back_i = 0;
  logic [127:0] key_i = '0;
  logic [31:0] sub_word_i, sub_word_o;
  logic [127:0] round_key_o;
  int checks = 0, errors = 0;
  logic [127:0] rk [13];

  always #(CLK_PERIOD/2) clk = ~clk;

  rks_top uut (.*);

  function automatic logic [7:0] m_dbl(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = m_dbl(a);
    end
    return p;
  endfunction
  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h01, base = x, s;
    for (int i = 0; i < 8; i++) begin
      if (8'd254 >> i & 1) inv = m_mul(inv, base);
      base = m_mul(base, base);
    end
    s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
        ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return s;
  endfunction
  function automatic logic [31:0] m_sub(input logic [31:0] w);
    return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
  endfunction
  function automatic logic [31:0] m_rot(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction
  function automatic logic [127:0] m_next(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] a, b, c, d;
    a = k[127:96] ^ m_sub(m_rot(k[31:0])) ^ {rc, 24'h0};
    b = k[95:64] ^ a;
    c = k[63:32] ^ b;
    d = k[31:0] ^ c;
    return {a, b, c, d};
  endfunction

  always_comb sub_word_i = m_sub(sub_word_o);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic build(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    rk[0] = k;
    for (int i = 1; i < 13; i++) begin
      rk[i] = m_next(rk[i-1], rc);
      rc = m_dbl(rc);
    end
  endtask
  task automatic do_load(input logic [127:0] k);
    @(negedge clk); load_i = 1; key_i = k;
    @(negedge clk); load_i = 0; key_i = $urandom;
  endtask
  task automatic do_step(input logic back);
    @(negedge clk); step_i = 1; dir_back_i = back;
    @(negedge clk); step_i = 0;
  endtask
  task automatic walk(input logic [127:0] k, input int n);
    build(k);
    do_load(k);
    for (int i = 1; i <= n; i++) begin
      do_step(0);
      check("R3 fwd", round_key_o, rk[i]);
    end
    for (int i = n - 1; i >= 0; i--) begin
      do_step(1);
      check("R5 back", round_key_o, rk[i]);
    end
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    check("R1 reset", round_key_o, '0);
    @(negedge clk); rst = 0;
    check("R1 after reset", round_key_o, '0);

    build(128'h2b7e151628aed2a6abf7158809cf4f3c);
    do_load(rk[0]);
    check("R2 load", round_key_o, rk[0]);
    do_step(0);
    check("R3 round1", round_key_o, 128'ha0fafe1788542cb123a339392a6c7605);
    for (int i = 2; i <= 10; i++) do_step(0);
    check("R4 round10", round_key_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    dir_back_i = 0; #1;
    check("R6 fwd word", {96'h0, sub_word_o}, {96'h0, m_rot(rk[10][31:0])});
    dir_back_i = 1; #1;
    check("R6 back word", {96'h0, sub_word_o},
          {96'h0, m_rot(rk[10][31:0] ^ rk[10][63:32])});
    for (int i = 9; i >= 0; i--) begin
      do_step(1);
      check("R5 back to key", round_key_o, rk[i]);
    end

    // R7: idle cycles with noisy inputs
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); dir_back_i = $urandom; key_i = {4{$urandom}};
    end
    @(negedge clk);
    check("R7 hold", round_key_o, rk[0]);

    // R8: load beats step; R2: rcon restarts after reload
    do_step(0); do_step(0);
    @(negedge clk); load_i = 1; step_i = 1; dir_back_i = 0; key_i = rk[0];
    @(negedge clk); load_i = 0; step_i = 0;
    check("R8 load wins", round_key_o, rk[0]);
    do_step(0);
    check("R2 rcon restart", round_key_o, rk[1]);

    walk(128'h2b7e151628aed2a6abf7158809cf4f3c, 12);
    walk('0, 10);
    walk('1, 11);
    for (int t = 0; t < 20; t++)
      walk({$urandom, $urandom, $urandom, $urandom}, 1 + ($urandom % 12));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule